// File: doc/BRIEF.md
# Four-Quadrant Flyback Mode Sequencer

This block steers the gate-drive enables of a single-stage bidirectional flyback inverter. It has one primary switch (Q1) and two secondary switches (Q2 and Q3). Once per switching period it samples two sign bits: the sign of the output current and the sign of the sinusoidal reference. From these it picks one of four operating modes. It then sends that period's PWM pulse and rectification pulse to the switch that the mode calls for. In two modes power flows back to the input through a passive diode, so no switch is driven during rectification.

All inputs are synchronous to the system clock `clk`. A switching period starts on a falling edge of `sw_clk`. The first part of the period is the PWM interval, which ends when the comparator input `pwm_cmp` drops or when `sw_clk` rises, whichever comes first. The rectification interval starts on the rising edge of `sw_clk`, after a programmable dead time. It lasts until the next period start, or until `rect_end` reports that the secondary current has run out. Any time left before the next period start is idle, with every gate off. A phase-reversal flag tells the feedback path to invert its polarity while the reference is negative. The block has no streaming data path: every pin is a plain level-sensitive control or status signal.

Top module: `flyback_quad_seq`

## Requirements
- R1: At a period start (a `clk` edge where `sw_clk` is sampled low after being sampled high at the previous edge, with `enable` high), the mode is latched from `{cur_neg, ref_neg}`. The encoding is {0,0} -> code 0 (mode 1), {1,0} -> code 1 (mode 2), {1,1} -> code 2 (mode 3) and {0,1} -> code 3 (mode 4). The code appears on `mode_code` after that edge.
- R2: `mode_code` changes only at a period start. A change of `cur_neg` or `ref_neg` in the middle of a period has no effect on the mode or the gates until the next period start.
- R3: The PWM gate turns on after the period-start edge. It is `gate_q1` in codes 0 and 2, `gate_q3` in code 1 and `gate_q2` in code 3. It turns off after the first edge at which `pwm_cmp` is sampled low or a rising `sw_clk` is sampled.
- R4: During rectification, `gate_q2` is on in code 0 and `gate_q3` is on in code 2. In codes 1 and 3 no gate is on during rectification.
- R5: The rectifier gate turns on no earlier than DEAD_CYC `clk` cycles after the PWM gate turns off. When `sw_clk` rises while the PWM gate is still on, the gate turns on after exactly DEAD_CYC cycles with all gates low. When the PWM gate turned off DEAD_CYC or more cycles before the rise, it turns on after the rising edge.
- R6: The rectifier gate turns off after the next period-start edge, or after the first edge at which `rect_end` is sampled high during rectification.
- R7: At most one of `gate_q1`, `gate_q2` and `gate_q3` is high at any time.
- R8: When `enable` is low, all gates go low in the same cycle without waiting for a clock edge. `mode_code` holds its value, and edges of `sw_clk` are ignored. Operation resumes at the first period start after `enable` returns high.
- R9: `phase_rev` is high exactly when the latched reference sign is negative (codes 2 and 3).
- R10: While `rst_n` is low and after it is released, all gates are low, `mode_code` is 0 and `phase_rev` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run enable; low forces all gates off at once |
| sw_clk | input | 1 | Switching clock; falling edge starts a period, rising edge starts rectification |
| pwm_cmp | input | 1 | PWM comparator result; low ends the PWM interval |
| cur_neg | input | 1 | Output current sign, 1 = negative |
| ref_neg | input | 1 | Sinusoidal reference sign, 1 = negative |
| rect_end | input | 1 | Secondary current has reached zero; ends rectification early |
| gate_q1 | output | 1 | Primary switch gate enable |
| gate_q2 | output | 1 | Positive-side secondary switch gate enable |
| gate_q3 | output | 1 | Negative-side secondary switch gate enable |
| mode_code | output | 2 | Latched operating mode, 0..3 for modes 1..4 |
| phase_rev | output | 1 | Feedback phase-reversal flag |

## Verification
The bench builds the block with a dead time of 3 cycles, while the default is 4. A dead window this short lets a single test end the PWM interval early in two ways. In one, the `sw_clk` rise comes well after the dead time has already run out, and the rectifier turns on right after the rising edge. In the other, the rise comes inside the dead time, and the rectifier waits for the remainder. The short window also keeps each four-mode sweep to a few dozen cycles, so every mode, the transition from rectification into the next PWM interval, early termination and the disable path each get a separate directed test.

// File: rtl/fqf_pkg.sv
`timescale 1ns/1ps
package fqf_pkg;

  localparam int NUM_SW = 3;
  localparam int SW_Q1  = 0;
  localparam int SW_Q2  = 1;
  localparam int SW_Q3  = 2;

  typedef enum logic [1:0] {
    MODE_FWD_POS = 2'd0,
    MODE_REV_POS = 2'd1,
    MODE_FWD_NEG = 2'd2,
    MODE_REV_NEG = 2'd3
  } fq_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_PWM  = 3'd1,
    ST_HOLD = 3'd2,
    ST_DEAD = 3'd3,
    ST_RECT = 3'd4
  } fq_state_e;

  typedef struct packed {
    logic [NUM_SW-1:0] pwm_sel;
    logic [NUM_SW-1:0] rect_sel;
  } fq_route_t;

  function automatic fq_mode_e decode_mode(input logic cur_n, input logic ref_n);
    fq_mode_e m;
    case ({cur_n, ref_n})
      2'b00:   m = MODE_FWD_POS;
      2'b10:   m = MODE_REV_POS;
      2'b11:   m = MODE_FWD_NEG;
      default: m = MODE_REV_NEG;
    endcase
    return m;
  endfunction

  function automatic fq_route_t route_of(input fq_mode_e m);
    fq_route_t r;
    r = '0;
    case (m)
      MODE_FWD_POS: begin
        r.pwm_sel[SW_Q1]  = 1'b1;
        r.rect_sel[SW_Q2] = 1'b1;
      end
      MODE_REV_POS: r.pwm_sel[SW_Q3] = 1'b1;
      MODE_FWD_NEG: begin
        r.pwm_sel[SW_Q1]  = 1'b1;
        r.rect_sel[SW_Q3] = 1'b1;
      end
      default:      r.pwm_sel[SW_Q2] = 1'b1;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/fqf_edge_det.sv
`timescale 1ns/1ps
module fqf_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic level_in,
  output logic rise_o,
  output logic fall_o
);

  logic level_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_q <= 1'b0;
    else        level_q <= level_in;
  end

  assign rise_o = level_in & ~level_q;
  assign fall_o = ~level_in & level_q;

endmodule

// File: rtl/fqf_mode_latch.sv
`timescale 1ns/1ps
module fqf_mode_latch
  import fqf_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     load_i,
  input  logic     cur_neg_i,
  input  logic     ref_neg_i,
  output fq_mode_e mode_o,
  output logic     ref_neg_o
);

  fq_mode_e mode_q;
  logic     ref_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_FWD_POS;
      ref_q  <= 1'b0;
    end else if (load_i) begin
      mode_q <= decode_mode(cur_neg_i, ref_neg_i);
      ref_q  <= ref_neg_i;
    end
  end

  assign mode_o    = mode_q;
  assign ref_neg_o = ref_q;

endmodule

// File: rtl/fqf_phase_fsm.sv
`timescale 1ns/1ps
module fqf_phase_fsm
  import fqf_pkg::*;
#(
  parameter int DEAD_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable_i,
  input  logic period_start_i,
  input  logic rect_start_i,
  input  logic pwm_cmp_i,
  input  logic rect_end_i,
  output logic load_o,
  output logic pwm_on_o,
  output logic rect_on_o
);

  localparam int CW = (DEAD_CYC < 2) ? 1 : $clog2(DEAD_CYC + 1);
  localparam logic [CW-1:0] CNT_MAX = CW'(DEAD_CYC);
  localparam logic [CW-1:0] DONE_AT = CW'(DEAD_CYC - 1);

  fq_state_e st_q, st_d;
  logic [CW-1:0] gap_q;
  logic dead_done;

  assign dead_done = (gap_q >= DONE_AT);

  always_comb begin
    st_d = st_q;
    if (!enable_i) begin
      st_d = ST_IDLE;
    end else if (period_start_i) begin
      st_d = ST_PWM;
    end else begin
      case (st_q)
        ST_IDLE: st_d = ST_IDLE;
        ST_PWM: begin
          if (rect_start_i)    st_d = ST_DEAD;
          else if (!pwm_cmp_i) st_d = ST_HOLD;
        end
        ST_HOLD: begin
          if (rect_start_i) st_d = dead_done ? ST_RECT : ST_DEAD;
        end
        ST_DEAD: begin
          if (dead_done) st_d = ST_RECT;
        end
        ST_RECT: begin
          if (rect_end_i) st_d = ST_IDLE;
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  // gap counter: cycles since the PWM gate went off
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q <= '0;
    end else if (st_q == ST_HOLD || st_q == ST_DEAD) begin
      if (gap_q < CNT_MAX) gap_q <= gap_q + 1'b1;
    end else begin
      gap_q <= '0;
    end
  end

  assign load_o    = enable_i & period_start_i;
  assign pwm_on_o  = (st_q == ST_PWM);
  assign rect_on_o = (st_q == ST_RECT);

endmodule

// File: rtl/fqf_gate_route.sv
`timescale 1ns/1ps
module fqf_gate_route
  import fqf_pkg::*;
(
  input  fq_mode_e          mode_i,
  input  logic              pwm_on_i,
  input  logic              rect_on_i,
  input  logic              enable_i,
  output logic [NUM_SW-1:0] gate_o
);

  fq_route_t sel;
  assign sel = route_of(mode_i);

  for (genvar g = 0; g < NUM_SW; g++) begin : g_sw
    assign gate_o[g] = enable_i &
                       ((pwm_on_i & sel.pwm_sel[g]) | (rect_on_i & sel.rect_sel[g]));
  end

endmodule

// File: rtl/flyback_quad_seq.sv
`timescale 1ns/1ps
module flyback_quad_seq
  import fqf_pkg::*;
#(
  parameter int DEAD_CYC = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic       sw_clk,
  input  logic       pwm_cmp,
  input  logic       cur_neg,
  input  logic       ref_neg,
  input  logic       rect_end,
  output logic       gate_q1,
  output logic       gate_q2,
  output logic       gate_q3,
  output logic [1:0] mode_code,
  output logic       phase_rev
);

  logic sw_rise, sw_fall, load, pwm_on, rect_on;
  fq_mode_e mode;
  logic [NUM_SW-1:0] gates;

  fqf_edge_det u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .level_in (sw_clk),
    .rise_o   (sw_rise),
    .fall_o   (sw_fall)
  );

  fqf_phase_fsm #(.DEAD_CYC(DEAD_CYC)) u_fsm (
    .clk            (clk),
    .rst_n          (rst_n),
    .enable_i       (enable),
    .period_start_i (sw_fall),
    .rect_start_i   (sw_rise),
    .pwm_cmp_i      (pwm_cmp),
    .rect_end_i     (rect_end),
    .load_o         (load),
    .pwm_on_o       (pwm_on),
    .rect_on_o      (rect_on)
  );

  fqf_mode_latch u_mode (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (load),
    .cur_neg_i (cur_neg),
    .ref_neg_i (ref_neg),
    .mode_o    (mode),
    .ref_neg_o (phase_rev)
  );

  fqf_gate_route u_route (
    .mode_i    (mode),
    .pwm_on_i  (pwm_on),
    .rect_on_i (rect_on),
    .enable_i  (enable),
    .gate_o    (gates)
  );

  assign gate_q1   = gates[SW_Q1];
  assign gate_q2   = gates[SW_Q2];
  assign gate_q3   = gates[SW_Q3];
  assign mode_code = mode;

endmodule

// File: rtl/fqf_seq_checker.sv
`timescale 1ns/1ps
module fqf_seq_checker #(
  parameter int DEAD_CYC = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       enable,
  input logic       sw_clk,
  input logic       rect_end,
  input logic       gate_q1,
  input logic       gate_q2,
  input logic       gate_q3,
  input logic [1:0] mode_code,
  input logic       phase_rev
);

  localparam int CW = $clog2(DEAD_CYC + 2);
  localparam logic [CW-1:0] OFF_MAX = CW'(DEAD_CYC);

  logic [CW-1:0] off_cnt;
  logic any_gate;
  assign any_gate = gate_q1 | gate_q2 | gate_q3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              off_cnt <= '0;
    else if (any_gate)       off_cnt <= '0;
    else if (off_cnt < OFF_MAX) off_cnt <= off_cnt + 1'b1;
  end

  p_one_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({gate_q3, gate_q2, gate_q1}) <= 1);

  p_mode_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> $stable(mode_code));

  p_mode_at_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mode_code) |-> ($past(enable) && !$past(sw_clk) && $past(sw_clk, 2)));

  p_dead_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (($rose(gate_q2) && mode_code == 2'd0) || ($rose(gate_q3) && mode_code == 2'd2))
      |-> (off_cnt >= OFF_MAX));

  p_no_rect_m2_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_code == 2'd1) |-> (!gate_q1 && !gate_q2));

  p_no_rect_m4_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_code == 2'd3) |-> (!gate_q1 && !gate_q3));

  p_rect_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rect_end && gate_q2 && mode_code == 2'd0) |=> !(gate_q2 && mode_code == 2'd0));

  p_phase_r9: assert property (@(posedge clk) disable iff (!rst_n)
    phase_rev == mode_code[1]);

endmodule

bind flyback_quad_seq fqf_seq_checker #(.DEAD_CYC(DEAD_CYC)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .enable    (enable),
  .sw_clk    (sw_clk),
  .rect_end  (rect_end),
  .gate_q1   (gate_q1),
  .gate_q2   (gate_q2),
  .gate_q3   (gate_q3),
  .mode_code (mode_code),
  .phase_rev (phase_rev)
);

// File: tb/flyback_quad_seq_tb_top.sv
`timescale 1ns/1ps
module flyback_quad_seq_tb_top;

  localparam int DEAD = 3;

  logic clk = 1'b0;
  logic rst_n, enable, sw_clk, pwm_cmp, cur_neg, ref_neg, rect_end;
  logic gate_q1, gate_q2, gate_q3, phase_rev;
  logic [1:0] mode_code;

  int n_checks = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  flyback_quad_seq #(.DEAD_CYC(DEAD)) dut_i (
    .clk (clk), .rst_n (rst_n), .enable (enable), .sw_clk (sw_clk),
    .pwm_cmp (pwm_cmp), .cur_neg (cur_neg), .ref_neg (ref_neg),
    .rect_end (rect_end), .gate_q1 (gate_q1), .gate_q2 (gate_q2),
    .gate_q3 (gate_q3), .mode_code (mode_code), .phase_rev (phase_rev)
  );

  function automatic int gv();
    return int'({gate_q3, gate_q2, gate_q1});
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // gate vector encoding {q3,q2,q1}: Q1=1, Q2=2, Q3=4
  task automatic start_period(input logic c, input logic r, input int exp_mode,
                              input int exp_pwm);
    @(negedge clk);
    cur_neg = c; ref_neg = r; pwm_cmp = 1'b1; sw_clk = 1'b0;
    @(negedge clk);
    check("R1 mode code", int'(mode_code), exp_mode);
    check("R3 pwm gate", gv(), exp_pwm);
    check("R9 phase flag", int'(phase_rev), int'(r));
    check("R7 single gate", $countones(gv()) <= 1 ? 1 : 0, 1);
  endtask

  task automatic rise_to_rect(input int exp_rect);
    @(negedge clk);
    sw_clk = 1'b1;
    @(negedge clk);
    check("R5 dead after pwm off", gv(), 0);
    for (int i = 1; i < DEAD; i++) begin
      @(negedge clk);
      check("R5 dead window", gv(), 0);
    end
    @(negedge clk);
    check("R4 rect gate", gv(), exp_rect);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; enable = 1'b1; sw_clk = 1'b1; pwm_cmp = 1'b0;
    cur_neg = 1'b0; ref_neg = 1'b0; rect_end = 1'b0;
    repeat (3) @(negedge clk);
    check("R10 gates in reset", gv(), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R10 gates after reset", gv(), 0);
    check("R10 mode after reset", int'(mode_code), 0);
    check("R10 phase after reset", int'(phase_rev), 0);
  endtask

  task automatic t_modes();
    start_period(1'b0, 1'b0, 0, 1); rise_to_rect(2);
    start_period(1'b1, 1'b0, 1, 4); rise_to_rect(0);
    start_period(1'b1, 1'b1, 2, 1); rise_to_rect(4);
    // R6: next period start while rectifying turns rect off, pwm on
    start_period(1'b0, 1'b1, 3, 2); rise_to_rect(0);
    start_period(1'b0, 1'b0, 0, 1); rise_to_rect(2);
  endtask

  task automatic t_early_end();
    // long gap: rect right after rise (R5)
    start_period(1'b0, 1'b0, 0, 1);
    @(negedge clk); pwm_cmp = 1'b0;
    @(negedge clk);
    check("R3 pwm ends on comparator", gv(), 0);
    repeat (DEAD + 2) @(negedge clk);
    check("R5 idle before rise", gv(), 0);
    sw_clk = 1'b1;
    @(negedge clk);
    check("R5 rect at rise after long gap", gv(), 2);
    // short gap: rise inside dead window
    start_period(1'b1, 1'b1, 2, 1);
    @(negedge clk); pwm_cmp = 1'b0;
    @(negedge clk); sw_clk = 1'b1;
    for (int i = 1; i < DEAD; i++) begin
      @(negedge clk);
      check("R5 short gap still dead", gv(), 0);
    end
    @(negedge clk);
    check("R5 rect after full dead", gv(), 4);
  endtask

  task automatic t_rect_end();
    start_period(1'b1, 1'b1, 2, 1); rise_to_rect(4);
    @(negedge clk); rect_end = 1'b1;
    @(negedge clk); rect_end = 1'b0;
    check("R6 rect_end stops rect", gv(), 0);
    @(negedge clk);
    check("R6 stays idle", gv(), 0);
  endtask

  task automatic t_midperiod();
    start_period(1'b0, 1'b0, 0, 1);
    @(negedge clk); cur_neg = 1'b1; ref_neg = 1'b1;
    @(negedge clk);
    check("R2 mode unchanged mid period", int'(mode_code), 0);
    check("R2 gate unchanged mid period", gv(), 1);
    rise_to_rect(2);
  endtask

  task automatic t_disable();
    start_period(1'b0, 1'b1, 3, 2);
    @(negedge clk); enable = 1'b0;
    #1;
    check("R8 gates drop at once", gv(), 0);
    cur_neg = 1'b1; ref_neg = 1'b1;
    @(negedge clk); sw_clk = 1'b1;
    @(negedge clk); sw_clk = 1'b0;
    @(negedge clk);
    check("R8 mode held while disabled", int'(mode_code), 3);
    check("R8 gates off while disabled", gv(), 0);
    enable = 1'b1;
    @(negedge clk);
    check("R8 no restart without period start", gv(), 0);
    sw_clk = 1'b1;
    repeat (DEAD + 2) @(negedge clk);
    check("R8 rise ignored when idle", gv(), 0);
    start_period(1'b1, 1'b1, 2, 1);
  endtask

  initial begin
    t_reset();
    t_modes();
    t_early_end();
    t_rect_end();
    t_midperiod();
    t_disable();
    repeat (4) @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", n_checks, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", n_checks, n_bad);
      $finish;
    end
  end

endmodule